// File: doc/BRIEF.md
# PS/2 Keyboard Receiver with ASCII Translation Queue

This block listens to the two open-collector lines of a PS/2 keyboard, assembles each 11-bit frame into a scan-code byte and attaches a translated ASCII byte for a fixed UK layout. Every received byte becomes one 16-bit entry in a deep queue that a processor polls over a small register port. The scan code sits in the low byte of the entry and the ASCII value in the byte above it.

A small tracker follows the make and release codes of both shift keys so the translation can choose between the plain and the shifted character. Release sequences (the 0xF0 prefix and the byte after it) are queued as well, with an ASCII byte of zero, so software can see key releases without decoding scan codes. The translation is fixed in logic and cannot be altered.

Software reads the head entry and a status word, neither of which changes the queue; any write removes the head entry. A frame with a parity or stop-bit error is thrown away, and a frame left half-finished by a silent clock line is abandoned after a programmable number of cycles.

Top module: `kbd_ascii_fifo`

## Requirements
- R1: After reset the status word (address 1) reads a count of 0 in bits [15:0], empty flag bit 16 = 1 and full flag bit 17 = 0, and the data word (address 0) reads 0.
- R2: A frame is a start bit 0, eight data bits least significant first, an odd parity bit and a stop bit 1, each sampled on a falling edge of the keyboard clock; a valid frame adds one entry whose bits [7:0] hold the data byte.
- R3: A frame whose parity bit does not make the count of ones in data plus parity odd adds no entry, and the next valid frame is received normally.
- R4: A frame whose stop bit is 0 adds no entry, and the next valid frame is received normally.
- R5: If a frame is in progress and no falling clock edge arrives for TIMEOUT_CYC cycles, the partial frame is abandoned and the next start bit begins a fresh frame.
- R6: With no shift key held, entry bits [15:8] hold lower-case letters (e.g. 0x1C gives 0x61), digits (0x16 gives 0x31, 0x45 gives 0x30), space 0x29 gives 0x20, enter 0x5A gives 0x0D and hash 0x5D gives 0x23.
- R7: A make of left shift 0x12 or right shift 0x59 sets its shift flag and its release clears it; while either flag is set, letters translate to upper case and UK symbols apply: 0x16 gives 0x21, 0x1E gives 0x22, 0x26 gives 0xA3, 0x52 gives 0x40, 0x5D gives 0x7E.
- R8: The release prefix 0xF0 is queued with ASCII 0, and the byte following it is queued with ASCII 0 and does not translate.
- R9: Codes outside the table, including the shift keys and the 0xE0 prefix, are queued with ASCII 0.
- R10: A read of address 0 returns the head entry in bits [15:0] with zeros above, and no read of either address changes the queue.
- R11: A write to the port removes one entry from the head; a write with the queue empty leaves the count at 0.
- R12: With DEPTH entries held, the full flag is 1, further received bytes are discarded, and the stored entries keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data line (asynchronous) |
| reg_addr_i | input | 1 | Register select: 0 head entry, 1 status |
| reg_wr_i | input | 1 | Write strobe; any write pops one entry |
| reg_rdata_o | output | 32 | Read data for the selected register |

## Verification
The hardest states to reach from the ports are a completely full queue and a frame cut off midway, because a polling consumer drains entries as fast as they arrive and a well-formed keyboard never stops mid-frame. The bench switches its polling monitor off, sends DEPTH plus two frames with a shortened queue depth, then drains by hand to check order and the dropped tail. For the cut-off frame it drives a start bit and a few data bits, holds the clock line idle past a shortened timeout, and then sends a complete frame that would be misread if the partial frame had survived.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int DATA_BITS = 8;

    typedef struct packed {
        logic [7:0] ascii;
        logic [7:0] scan;
    } kbd_entry_t;

    localparam logic [7:0] SC_RELEASE = 8'hF0;
    localparam logic [7:0] SC_LSHIFT  = 8'h12;
    localparam logic [7:0] SC_RSHIFT  = 8'h59;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_e;

    // Lower-case letter for a set-2 code, or zero when the code is no letter.
    function automatic logic [7:0] letter_of(input logic [7:0] sc);
        logic [7:0] r;
        case (sc)
            8'h1C: r = 8'h61;  8'h32: r = 8'h62;  8'h21: r = 8'h63;
            8'h23: r = 8'h64;  8'h24: r = 8'h65;  8'h2B: r = 8'h66;
            8'h34: r = 8'h67;  8'h33: r = 8'h68;  8'h43: r = 8'h69;
            8'h3B: r = 8'h6A;  8'h42: r = 8'h6B;  8'h4B: r = 8'h6C;
            8'h3A: r = 8'h6D;  8'h31: r = 8'h6E;  8'h44: r = 8'h6F;
            8'h4D: r = 8'h70;  8'h15: r = 8'h71;  8'h2D: r = 8'h72;
            8'h1B: r = 8'h73;  8'h2C: r = 8'h74;  8'h3C: r = 8'h75;
            8'h2A: r = 8'h76;  8'h1D: r = 8'h77;  8'h22: r = 8'h78;
            8'h35: r = 8'h79;  8'h1A: r = 8'h7A;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    // Full UK translation; zero for anything outside the table.
    function automatic logic [7:0] key_ascii(input logic [7:0] sc, input logic shifted);
        logic [7:0] lc;
        logic [7:0] r;
        lc = letter_of(sc);
        if (lc != 8'h00) begin
            r = shifted ? (lc - 8'd32) : lc;
        end else begin
            case (sc)
                8'h16: r = shifted ? 8'h21 : 8'h31;
                8'h1E: r = shifted ? 8'h22 : 8'h32;
                8'h26: r = shifted ? 8'hA3 : 8'h33;
                8'h25: r = shifted ? 8'h24 : 8'h34;
                8'h2E: r = shifted ? 8'h25 : 8'h35;
                8'h36: r = shifted ? 8'h5E : 8'h36;
                8'h3D: r = shifted ? 8'h26 : 8'h37;
                8'h3E: r = shifted ? 8'h2A : 8'h38;
                8'h46: r = shifted ? 8'h28 : 8'h39;
                8'h45: r = shifted ? 8'h29 : 8'h30;
                8'h4E: r = shifted ? 8'h5F : 8'h2D;
                8'h55: r = shifted ? 8'h2B : 8'h3D;
                8'h41: r = shifted ? 8'h3C : 8'h2C;
                8'h49: r = shifted ? 8'h3E : 8'h2E;
                8'h4A: r = shifted ? 8'h3F : 8'h2F;
                8'h4C: r = shifted ? 8'h3A : 8'h3B;
                8'h52: r = shifted ? 8'h40 : 8'h27;
                8'h5D: r = shifted ? 8'h7E : 8'h23;
                8'h54: r = shifted ? 8'h7B : 8'h5B;
                8'h5B: r = shifted ? 8'h7D : 8'h5D;
                8'h61: r = shifted ? 8'h7C : 8'h5C;
                8'h0E: r = shifted ? 8'hAC : 8'h60;
                8'h29: r = 8'h20;
                8'h5A: r = 8'h0D;
                8'h66: r = 8'h08;
                8'h0D: r = 8'h09;
                8'h76: r = 8'h1B;
                default: r = 8'h00;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    localparam int WD_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int CNT_W = $clog2(DATA_BITS);

    logic [2:0]             clk_sync;
    logic [1:0]             dat_sync;
    logic                   fall;
    logic                   bit_in;
    rx_phase_e              phase;
    logic [DATA_BITS-1:0]   shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   par_bit;
    logic [WD_W-1:0]        wd_cnt;
    logic                   wd_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '1;
            dat_sync <= '1;
        end else begin
            clk_sync <= {clk_sync[1:0], ps2_clk_i};
            dat_sync <= {dat_sync[0], ps2_dat_i};
        end
    end

    assign fall   = clk_sync[2] & ~clk_sync[1];
    assign bit_in = dat_sync[1];
    assign wd_hit = (wd_cnt == WD_W'(TIMEOUT_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            par_bit    <= 1'b0;
            wd_cnt     <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_vld_o <= 1'b0;
            if (fall || phase == PH_IDLE) begin
                wd_cnt <= '0;
            end else if (!wd_hit) begin
                wd_cnt <= wd_cnt + 1'b1;
            end
            if (fall) begin
                case (phase)
                    PH_IDLE: begin
                        if (!bit_in) begin
                            phase   <= PH_DATA;
                            bit_cnt <= '0;
                        end
                    end
                    PH_DATA: begin
                        shreg   <= {bit_in, shreg[DATA_BITS-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(DATA_BITS - 1)) phase <= PH_PARITY;
                    end
                    PH_PARITY: begin
                        par_bit <= bit_in;
                        phase   <= PH_STOP;
                    end
                    default: begin
                        phase <= PH_IDLE;
                        if (bit_in && ((^shreg) ^ par_bit)) begin
                            byte_vld_o <= 1'b1;
                            byte_o     <= shreg;
                        end
                    end
                endcase
            end else if (wd_hit) begin
                phase <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/kbd_xlate.sv
module kbd_xlate
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output logic       push_o,
    output kbd_entry_t entry_o
);
    logic rel_pend;
    logic lshift;
    logic rshift;
    kbd_entry_t nxt;

    always_comb begin
        nxt.scan = byte_i;
        if (byte_i == SC_RELEASE || rel_pend) begin
            nxt.ascii = 8'h00;
        end else begin
            nxt.ascii = key_ascii(byte_i, lshift | rshift);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_pend <= 1'b0;
            lshift   <= 1'b0;
            rshift   <= 1'b0;
            push_o   <= 1'b0;
            entry_o  <= '0;
        end else begin
            push_o <= byte_vld_i;
            if (byte_vld_i) begin
                entry_o <= nxt;
                if (byte_i == SC_RELEASE) begin
                    rel_pend <= 1'b1;
                end else begin
                    rel_pend <= 1'b0;
                    if (byte_i == SC_LSHIFT) lshift <= !rel_pend;
                    if (byte_i == SC_RSHIFT) rshift <= !rel_pend;
                end
            end
        end
    end
endmodule

// File: rtl/kbd_entry_fifo.sv
module kbd_entry_fifo
    import kbd_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  kbd_entry_t                 din_i,
    input  logic                       pop_i,
    output kbd_entry_t                 head_o,
    output logic [$clog2(DEPTH):0]     count_o,
    output logic                       empty_o,
    output logic                       full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    kbd_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count_o == '0);
    assign full_o  = (count_o == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end
endmodule

// File: rtl/kbd_ascii_fifo.sv
module kbd_ascii_fifo
    import kbd_pkg::*;
#(
    parameter int DEPTH       = 512,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ps2_clk_i,
    input  logic        ps2_dat_i,
    input  logic        reg_addr_i,
    input  logic        reg_wr_i,
    output logic [31:0] reg_rdata_o
);
    localparam int CW        = $clog2(DEPTH) + 1;
    localparam int EMPTY_BIT = 16;
    localparam int FULL_BIT  = 17;

    logic          frame_vld;
    logic [7:0]    frame_byte;
    logic          xl_push;
    kbd_entry_t    xl_entry;
    kbd_entry_t    head;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_empty;
    logic          fifo_full;
    logic [31:0]   status;

    kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .ps2_clk_i  (ps2_clk_i),
        .ps2_dat_i  (ps2_dat_i),
        .byte_vld_o (frame_vld),
        .byte_o     (frame_byte)
    );

    kbd_xlate u_xlate (
        .clk        (clk),
        .rst        (rst),
        .byte_vld_i (frame_vld),
        .byte_i     (frame_byte),
        .push_o     (xl_push),
        .entry_o    (xl_entry)
    );

    kbd_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (xl_push),
        .din_i   (xl_entry),
        .pop_i   (reg_wr_i),
        .head_o  (head),
        .count_o (fifo_cnt),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    always_comb begin
        status            = '0;
        status[CW-1:0]    = fifo_cnt;
        status[EMPTY_BIT] = fifo_empty;
        status[FULL_BIT]  = fifo_full;
    end

    always_comb begin
        if (reg_addr_i) begin
            reg_rdata_o = status;
        end else if (fifo_empty) begin
            reg_rdata_o = '0;
        end else begin
            reg_rdata_o = {16'h0000, head};
        end
    end
endmodule

// File: rtl/kbd_ascii_fifo_chk.sv
module kbd_ascii_fifo_chk #(
    parameter int DEPTH = 512
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_wr,
    input logic                   frame_vld,
    input logic                   push,
    input logic [15:0]            entry,
    input logic [$clog2(DEPTH):0] count
);
    localparam int CW = $clog2(DEPTH) + 1;

    p_push_after_frame_r2: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> push);

    p_no_spurious_push_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> !push);

    p_release_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (push && entry[7:0] == 8'hF0) |-> (entry[15:8] == 8'h00));

    p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_write_pops_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && count != '0 && !push) |=> (count == $past(count) - 1'b1));

    p_read_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && !push) |=> $stable(count));

    p_full_drops_r12: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && push && !reg_wr) |=> (count == CW'(DEPTH)));
endmodule

bind kbd_ascii_fifo kbd_ascii_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr_i),
    .frame_vld (frame_vld),
    .push      (xl_push),
    .entry     (xl_entry),
    .count     (fifo_cnt)
);

// File: tb/test_kbd_ascii_fifo.sv
module test_kbd_ascii_fifo;
    localparam int DEPTH   = 16;
    localparam int TMO     = 300;
    localparam int HP      = 10;
    localparam int MAX_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ps2_clk = 1'b1;
    logic        ps2_dat = 1'b1;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;
    bit mon_en = 0;
    logic [15:0] exp_q[$];

    kbd_ascii_fifo #(.DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) i_kbd_ascii_fifo (
        .clk         (clk),
        .rst         (rst),
        .ps2_clk_i   (ps2_clk),
        .ps2_dat_i   (ps2_dat),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_rdata_o (reg_rdata)
    );

    always #2 clk = ~clk;   // 4-unit period, nominal 250 MHz

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_test();
        end
    end

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bus_pop();
        @(negedge clk);
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ps2_bit(input logic b);
        ps2_dat = b;
        repeat (HP) @(negedge clk);
        ps2_clk = 1'b0;
        repeat (HP) @(negedge clk);
        ps2_clk = 1'b1;
    endtask

    task automatic send_raw(input logic [7:0] b, input logic par_flip, input logic stop);
        ps2_bit(1'b0);
        for (int i = 0; i < 8; i++) ps2_bit(b[i]);
        ps2_bit((~^b) ^ par_flip);
        ps2_bit(stop);
        ps2_dat = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    // Driver: sends a good frame and queues the entry the requirements predict.
    task automatic send_key(input logic [7:0] sc, input logic [7:0] asc);
        exp_q.push_back({asc, sc});
        send_raw(sc, 1'b0, 1'b1);
    endtask

    // Monitor: polls status and compares each head entry against the scoreboard.
    always begin
        logic [31:0] st;
        logic [31:0] d;
        logic [15:0] e;
        @(negedge clk);
        if (mon_en && !done) begin
            bus_read(1'b1, st);
            if (st[15:0] != 16'd0) begin
                bus_read(1'b0, d);
                if (exp_q.size() == 0) begin
                    check("R2 unexpected entry", d, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check("R2/R6/R7/R8/R9 entry", d, {16'h0, e});
                end
                bus_pop();
            end
        end
    end

    task automatic drain(input string tag);
        int t = 0;
        logic [31:0] st;
        while (exp_q.size() != 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
        mon_en = 0;
        repeat (12) @(negedge clk);
        check({tag, " scoreboard drained"}, exp_q.size(), 0);
        bus_read(1'b1, st);
        check({tag, " queue empty"}, st[17:0], 18'h10000);
        mon_en = 1;
    endtask

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        bus_read(1'b1, d);
        check("R1 status after reset", d, 32'h0001_0000);
        bus_read(1'b0, d);
        check("R1 data after reset", d, 32'h0);

        mon_en = 1;
        // R2, R6: unshifted keys
        send_key(8'h1C, 8'h61);
        send_key(8'h32, 8'h62);
        send_key(8'h1A, 8'h7A);
        send_key(8'h16, 8'h31);
        send_key(8'h45, 8'h30);
        send_key(8'h29, 8'h20);
        send_key(8'h5A, 8'h0D);
        send_key(8'h5D, 8'h23);
        drain("R6");

        // R8: release of a letter, then the letter translates again
        send_key(8'hF0, 8'h00);
        send_key(8'h1C, 8'h00);
        send_key(8'h1C, 8'h61);
        drain("R8");

        // R7: left shift held
        send_key(8'h12, 8'h00);
        send_key(8'h1C, 8'h41);
        send_key(8'h16, 8'h21);
        send_key(8'h1E, 8'h22);
        send_key(8'h26, 8'hA3);
        send_key(8'h52, 8'h40);
        send_key(8'h5D, 8'h7E);
        send_key(8'hF0, 8'h00);
        send_key(8'h12, 8'h00);
        send_key(8'h1C, 8'h61);
        // R7: both shifts, release one, then the other
        send_key(8'h12, 8'h00);
        send_key(8'h59, 8'h00);
        send_key(8'hF0, 8'h00);
        send_key(8'h12, 8'h00);
        send_key(8'h1A, 8'h5A);
        send_key(8'hF0, 8'h00);
        send_key(8'h59, 8'h00);
        send_key(8'h1A, 8'h7A);
        drain("R7");

        // R9: codes outside the table
        send_key(8'hE0, 8'h00);
        send_key(8'h05, 8'h00);
        drain("R9");

        // R3: bad parity dropped, next frame fine
        send_raw(8'h1C, 1'b1, 1'b1);
        send_key(8'h32, 8'h62);
        drain("R3");

        // R4: bad stop bit dropped, next frame fine
        send_raw(8'h24, 1'b0, 1'b0);
        repeat (TMO + 20) @(negedge clk);
        send_key(8'h24, 8'h65);
        drain("R4");

        // R5: partial frame abandoned after the timeout
        ps2_bit(1'b0);
        ps2_bit(1'b1);
        ps2_bit(1'b0);
        ps2_bit(1'b1);
        ps2_dat = 1'b1;
        repeat (TMO + 50) @(negedge clk);
        send_key(8'h3A, 8'h6D);
        drain("R5");

        // R10, R11: reads do not pop, writes do
        mon_en = 0;
        repeat (12) @(negedge clk);
        send_raw(8'h1C, 1'b0, 1'b1);
        send_raw(8'h32, 1'b0, 1'b1);
        bus_read(1'b0, d);
        check("R10 head read", d, 32'h0000_611C);
        bus_read(1'b0, d);
        check("R10 head re-read unchanged", d, 32'h0000_611C);
        bus_read(1'b1, d);
        check("R10 status count 2", d, 32'h0000_0002);
        bus_pop();
        bus_read(1'b0, d);
        check("R11 head after pop", d, 32'h0000_6232);
        bus_read(1'b1, d);
        check("R11 count after pop", d, 32'h0000_0001);
        bus_pop();
        bus_read(1'b1, d);
        check("R11 empty after second pop", d, 32'h0001_0000);
        bus_pop();
        bus_read(1'b1, d);
        check("R11 pop on empty", d, 32'h0001_0000);

        // R12: fill past capacity, extras discarded, order kept
        for (int i = 0; i < DEPTH + 2; i++) send_raw(8'h80 + 8'(i), 1'b0, 1'b1);
        bus_read(1'b1, d);
        check("R12 full status", d, 32'h0002_0000 | 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(1'b0, d);
            check("R12 drained order", d, {24'h0, 8'h80 + 8'(i)});
            bus_pop();
        end
        bus_read(1'b1, d);
        check("R12 empty after drain", d, 32'h0001_0000);

        // R2: normal operation after pointer wrap
        mon_en = 1;
        send_key(8'h44, 8'h6F);
        send_key(8'h4D, 8'h70);
        drain("R2");

        finish_test();
    end
endmodule